// File: doc/BRIEF.md
# Debug Program-Counter Sample Context Capture Register

This block is a read-only debug register. It records the execution context that goes with a program-counter sample. The neighbouring sample register raises a one-cycle strobe when its low word is read. On that strobe, the block takes in the live context and stores it as one 32-bit word:

- the security state;
- the current exception level;
- the execution width of the hypervisor stage;
- the virtual machine identifier and its size control;
- the hypervisor context identifier;
- whether the sample's upper half is nonzero.

Reading this register over a small memory-mapped debug bus returns that stored word. The read itself captures nothing.

Two layouts are supported, and a format-select input picks between them at capture time:

- **Flag layout:** status flags in the top bits and the VMID in the low half.
- **Context-ID layout:** the whole word holds the hypervisor context identifier.

Parameters say whether EL2, EL3 (and its 64-bit state), 16-bit VMIDs and the context-ID layout exist. Fields that belong to absent features read as zero.

Bus accesses at the register's offset get a registered response one cycle later. The response is an error whenever the core is unpowered or either lock is set. Writes never change the stored word.

Top module: `dbg_ctx_snap`

## Requirements
- R1: A cycle with `pcs_lo_rd` high stores a new snapshot at that clock edge. A read of this register captures nothing and returns the word stored before the read's cycle.
- R2: In the flag layout, the word is built as follows:
  - bit 31 = non-secure flag (`ctx_ns`);
  - bit 30 = 1 when `ctx_el` is 2;
  - bit 29 = 1 when `ctx_el` is 3 (with EL3 in 64-bit state);
  - bit 28 = upper-half hint;
  - bits 27:16 = 0;
  - bits 15:0 = VMID.
- R3: The VMID field stores zero when `ctx_ns` is 0 or `ctx_el` is 2.
- R4: With `hyp_aa64`=1, 16-bit VMID support and `vmid_wide`=0, only VMID bits 7:0 are stored, and bits 15:8 are 0. Otherwise, with 16-bit support, all 16 bits are stored.
- R5: When `fmt_sel`=1 and the context-ID layout exists, the word is `cid_in` if `hyp_aa64`=1 and `ctx_ns`=1, and zero otherwise.
- R6: Bit 28 is 1 exactly when `pcs_hi_word` is nonzero at capture.
- R7: An access is accepted only at offset 0x0A8. It is answered with an error (`rsp_err`=1, data 0) when `pwr_on`=0, `dbl_lock`=1 or `os_lock`=1, and otherwise with OKAY and the snapshot.
- R8: Writes leave the snapshot unchanged. They get the same OKAY/error response as a read, with data 0.
- R9: After reset, the snapshot reads as zero.
- R10: The layout is chosen at capture time. Changing `fmt_sel` after a capture does not alter what is read.
- R11: Without EL2, bit 30 and the VMID read zero. Without EL3, bit 29 reads zero. Without 16-bit VMID support, bits 15:8 read zero. Without the context-ID layout, `fmt_sel` is ignored.
- R12: An access at any other offset produces no response (`rsp_valid` stays 0).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pwr_on | input | 1 | Core power status |
| dbl_lock | input | 1 | Double-lock status |
| os_lock | input | 1 | OS-lock status |
| pcs_lo_rd | input | 1 | Strobe: low word of the PC sample was read |
| pcs_hi_word | input | 32 | Upper half of the PC sample |
| ctx_ns | input | 1 | 1 = non-secure state |
| ctx_el | input | 2 | Current exception level |
| hyp_aa64 | input | 1 | Hypervisor stage runs in 64-bit state |
| vmid_in | input | 16 | Live VMID |
| vmid_wide | input | 1 | VMID size control (1 = 16-bit) |
| cid_in | input | 32 | Live hypervisor context identifier |
| fmt_sel | input | 1 | Layout select (1 = context-ID layout) |
| req_valid | input | 1 | Bus request |
| req_write | input | 1 | 1 = write |
| req_addr | input | ADDR_W | Byte offset |
| rsp_valid | output | 1 | Response valid, one cycle after request |
| rsp_err | output | 1 | Error response |
| rsp_rdata | output | 32 | Read data |

## Verification
The hardest situation to reach from the ports is a snapshot whose meaning depends on context that has since changed. Examples:
- a context-ID word captured, and `fmt_sel` then cleared before the read;
- a VMID captured in a secure or EL2 state, and the state then changed.

The stimulus reaches these by changing every context input at random between each capture and its read. It also interleaves random writes and lock changes between them. A feature-reduced second instance receives the same stimulus, so that the zeroing of absent fields is covered.

// File: rtl/dbg_ctx_pkg.sv
package dbg_ctx_pkg;

  typedef struct packed {
    logic        ns;
    logic [1:0]  el;
    logic        hyp_aa64;
    logic [15:0] vmid;
    logic        vmid_wide;
    logic [31:0] cid;
    logic        hi_nz;
  } ctx_t;

  localparam logic [1:0] EL_HYP = 2'd2;
  localparam logic [1:0] EL_MON = 2'd3;

  // VMID value kept in the flag layout
  function automatic logic [15:0] vmid_pick(ctx_t c, bit has_el2, bit has_v16);
    logic [15:0] v;
    v = c.vmid;
    if (!has_v16 || (c.hyp_aa64 && !c.vmid_wide))
      v[15:8] = 8'h00;
    if (!has_el2 || !c.ns || c.el == EL_HYP)
      v = 16'h0000;
    return v;
  endfunction

  function automatic logic [31:0] flag_word(ctx_t c, bit has_el2, bit has_el3,
                                            bit el3_aa64, bit has_v16);
    logic [31:0] w;
    w        = '0;
    w[31]    = c.ns;
    w[30]    = has_el2 && (c.el == EL_HYP);
    w[29]    = has_el3 && el3_aa64 && (c.el == EL_MON);
    w[28]    = c.hi_nz;
    w[15:0]  = vmid_pick(c, has_el2, has_v16);
    return w;
  endfunction

  function automatic logic [31:0] cid_word(ctx_t c);
    return (c.hyp_aa64 && c.ns) ? c.cid : 32'h0;
  endfunction

  function automatic logic access_ok(logic pwr, logic dlk, logic olk);
    return pwr && !dlk && !olk;
  endfunction

endpackage

// File: rtl/ctx_fmt.sv
module ctx_fmt
  import dbg_ctx_pkg::*;
#(
  parameter bit HAS_EL2     = 1'b1,
  parameter bit HAS_EL3     = 1'b1,
  parameter bit EL3_AA64    = 1'b1,
  parameter bit HAS_VMID16  = 1'b1,
  parameter bit HAS_CID_FMT = 1'b1
) (
  input  ctx_t        ctx,
  input  logic        fmt_sel,
  output logic        cid_mode,
  output logic [31:0] word
);
  always_comb begin
    cid_mode = HAS_CID_FMT && fmt_sel;
    if (cid_mode) word = cid_word(ctx);
    else          word = flag_word(ctx, HAS_EL2, HAS_EL3, EL3_AA64, HAS_VMID16);
  end
endmodule

// File: rtl/ctx_store.sv
module ctx_store #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cap,
  input  logic [W-1:0] word,
  output logic [W-1:0] snap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   snap <= '0;
    else if (cap) snap <= word;
  end
endmodule

// File: rtl/ctx_bus.sv
module ctx_bus
  import dbg_ctx_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter int                W       = 32,
  parameter logic [ADDR_W-1:0] REG_OFF = 12'h0A8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              dbl_lock,
  input  logic              os_lock,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [W-1:0]      snap,
  output logic              req_hit,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [W-1:0]      rsp_rdata
);
  logic ok;
  assign req_hit = req_valid && (req_addr == REG_OFF);
  assign ok      = access_ok(pwr_on, dbl_lock, os_lock);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_hit;
      rsp_err   <= req_hit && !ok;
      rsp_rdata <= (req_hit && ok && !req_write) ? snap : '0;
    end
  end
endmodule

// File: rtl/dbg_ctx_snap.sv
module dbg_ctx_snap
  import dbg_ctx_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] REG_OFF     = 12'h0A8,
  parameter bit                HAS_EL2     = 1'b1,
  parameter bit                HAS_EL3     = 1'b1,
  parameter bit                EL3_AA64    = 1'b1,
  parameter bit                HAS_VMID16  = 1'b1,
  parameter bit                HAS_CID_FMT = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pwr_on,
  input  logic              dbl_lock,
  input  logic              os_lock,
  input  logic              pcs_lo_rd,
  input  logic [31:0]       pcs_hi_word,
  input  logic              ctx_ns,
  input  logic [1:0]        ctx_el,
  input  logic              hyp_aa64,
  input  logic [15:0]       vmid_in,
  input  logic              vmid_wide,
  input  logic [31:0]       cid_in,
  input  logic              fmt_sel,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              rsp_valid,
  output logic              rsp_err,
  output logic [31:0]       rsp_rdata
);
  localparam int W = 32;

  ctx_t         ctx;
  logic         cap_evt;
  logic         cid_mode;
  logic         req_hit;
  logic [W-1:0] new_word;
  logic [W-1:0] snap_q;

  always_comb begin
    ctx.ns        = ctx_ns;
    ctx.el        = ctx_el;
    ctx.hyp_aa64  = hyp_aa64;
    ctx.vmid      = vmid_in;
    ctx.vmid_wide = vmid_wide;
    ctx.cid       = cid_in;
    ctx.hi_nz     = |pcs_hi_word;
  end

  assign cap_evt = pcs_lo_rd;

  ctx_fmt #(
    .HAS_EL2(HAS_EL2), .HAS_EL3(HAS_EL3), .EL3_AA64(EL3_AA64),
    .HAS_VMID16(HAS_VMID16), .HAS_CID_FMT(HAS_CID_FMT)
  ) u_fmt (
    .ctx(ctx), .fmt_sel(fmt_sel), .cid_mode(cid_mode), .word(new_word)
  );

  ctx_store #(.W(W)) u_store (
    .clk(clk), .rst_n(rst_n), .cap(cap_evt), .word(new_word), .snap(snap_q)
  );

  ctx_bus #(.ADDR_W(ADDR_W), .W(W), .REG_OFF(REG_OFF)) u_bus (
    .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .dbl_lock(dbl_lock),
    .os_lock(os_lock), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .snap(snap_q), .req_hit(req_hit),
    .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );
endmodule

// File: rtl/dbg_ctx_snap_chk.sv
module dbg_ctx_snap_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        pwr_on,
  input logic        dbl_lock,
  input logic        os_lock,
  input logic        req_valid,
  input logic        req_hit,
  input logic        cap_evt,
  input logic        cid_mode,
  input logic        ctx_ns,
  input logic [1:0]  ctx_el,
  input logic [31:0] snap_q,
  input logic        rsp_valid,
  input logic        rsp_err,
  input logic [31:0] rsp_rdata
);
  AST_HOLD_NO_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cap_evt) |-> $stable(snap_q)); // R8

  AST_RSV_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_evt && !cid_mode) |-> snap_q[27:16] == 12'h0); // R2

  AST_VMID_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cap_evt && !cid_mode && (!ctx_ns || ctx_el == 2'd2)) |-> snap_q[15:0] == 16'h0); // R3

  AST_LOCK_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_hit && (!pwr_on || dbl_lock || os_lock)) |-> rsp_valid && rsp_err); // R7

  AST_ERR_NODATA: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_rdata == 32'h0); // R7

  AST_MISS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(req_valid && !req_hit) |-> !rsp_valid); // R12
endmodule

bind dbg_ctx_snap dbg_ctx_snap_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .dbl_lock(dbl_lock),
  .os_lock(os_lock), .req_valid(req_valid), .req_hit(req_hit),
  .cap_evt(cap_evt), .cid_mode(cid_mode), .ctx_ns(ctx_ns), .ctx_el(ctx_el),
  .snap_q(snap_q), .rsp_valid(rsp_valid), .rsp_err(rsp_err),
  .rsp_rdata(rsp_rdata)
);

// File: tb/tb_dbg_ctx_snap.sv
module tb_dbg_ctx_snap;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic pwr_on = 1'b1, dbl_lock = 1'b0, os_lock = 1'b0;
  logic pcs_lo_rd = 1'b0;
  logic [31:0] pcs_hi_word = '0;
  logic ctx_ns = 1'b0;
  logic [1:0] ctx_el = '0;
  logic hyp_aa64 = 1'b0;
  logic [15:0] vmid_in = '0;
  logic vmid_wide = 1'b0;
  logic [31:0] cid_in = '0;
  logic fmt_sel = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic rsp_valid, rsp_err, m_valid, m_err;
  logic [31:0] rsp_rdata, m_rdata;

  int checks = 0, errors = 0;
  logic [31:0] exp_full = '0, exp_min = '0;

  always #5 clk = ~clk;

  dbg_ctx_snap dut (
    .clk, .rst_n, .pwr_on, .dbl_lock, .os_lock, .pcs_lo_rd, .pcs_hi_word,
    .ctx_ns, .ctx_el, .hyp_aa64, .vmid_in, .vmid_wide, .cid_in, .fmt_sel,
    .req_valid, .req_write, .req_addr, .rsp_valid, .rsp_err, .rsp_rdata);

  dbg_ctx_snap #(.HAS_EL2(1'b0), .HAS_EL3(1'b0), .HAS_VMID16(1'b0),
                 .HAS_CID_FMT(1'b0)) dut_min (
    .clk, .rst_n, .pwr_on, .dbl_lock, .os_lock, .pcs_lo_rd, .pcs_hi_word,
    .ctx_ns, .ctx_el, .hyp_aa64, .vmid_in, .vmid_wide, .cid_in, .fmt_sel,
    .req_valid, .req_write, .req_addr,
    .rsp_valid(m_valid), .rsp_err(m_err), .rsp_rdata(m_rdata));

  // Expected snapshot from the requirements; full = all features present
  function automatic logic [31:0] model(bit full);
    logic [31:0] r;
    if (full && fmt_sel)
      return (hyp_aa64 && ctx_ns) ? cid_in : 32'h0;
    r = 32'h0;
    r[31] = ctx_ns;
    r[28] = (pcs_hi_word != 0);
    if (full) begin
      r[30] = (ctx_el == 2'd2);
      r[29] = (ctx_el == 2'd3);
      if (ctx_ns && ctx_el != 2'd2)
        r[15:0] = (hyp_aa64 && !vmid_wide) ? {8'h00, vmid_in[7:0]} : vmid_in;
    end
    return r;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic randomize_ctx();
    ctx_ns      = 1'($urandom);
    ctx_el      = 2'($urandom);
    hyp_aa64    = 1'($urandom);
    vmid_in     = 16'($urandom);
    vmid_wide   = 1'($urandom);
    cid_in      = $urandom;
    fmt_sel     = 1'($urandom);
    pcs_hi_word = ($urandom % 3 == 0) ? 32'h0 : $urandom;
  endtask

  task automatic capture();
    @(negedge clk);
    pcs_lo_rd = 1'b1;
    exp_full = model(1'b1);
    exp_min  = model(1'b0);
    @(negedge clk);
    pcs_lo_rd = 1'b0;
  endtask

  // One bus access; checks both instances' responses
  task automatic access(string tag, bit wr, logic [11:0] addr);
    bit ok, hit;
    ok  = pwr_on && !dbl_lock && !os_lock;
    hit = (addr == 12'h0A8);
    @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = addr;
    @(negedge clk);
    req_valid = 1'b0;
    check({tag, " valid"}, {31'h0, rsp_valid}, {31'h0, hit});
    if (hit) begin
      check({tag, " err"}, {31'h0, rsp_err}, {31'h0, !ok});
      check({tag, " data"}, rsp_rdata, (ok && !wr) ? exp_full : 32'h0);
      check({tag, " R11 min data"}, m_rdata, (ok && !wr) ? exp_min : 32'h0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_0a8));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R9 reset value
    access("R9 reset", 1'b0, 12'h0A8);

    // R2/R3/R4 directed: non-secure EL1, 64-bit hyp, narrow VMID
    ctx_ns = 1; ctx_el = 1; hyp_aa64 = 1; vmid_in = 16'hABCD; vmid_wide = 0;
    fmt_sel = 0; pcs_hi_word = 0; cid_in = 32'h1234_5678;
    capture(); access("R4 narrow vmid", 1'b0, 12'h0A8);
    check("R4 narrow expect", exp_full, 32'h8000_00CD);
    vmid_wide = 1; capture(); access("R4 wide vmid", 1'b0, 12'h0A8);
    check("R4 wide expect", exp_full, 32'h8000_ABCD);
    // R3 secure and EL2 zero the VMID; R6 hint
    ctx_ns = 0; pcs_hi_word = 32'h1; capture(); access("R3 secure", 1'b0, 12'h0A8);
    check("R6 hint expect", exp_full, 32'h1000_0000);
    ctx_ns = 1; ctx_el = 2; capture(); access("R3 at EL2 R2", 1'b0, 12'h0A8);
    ctx_el = 3; pcs_hi_word = 0; capture(); access("R2 EL3 flag", 1'b0, 12'h0A8);
    // R5 context-ID layout, then R10 change format after capture
    fmt_sel = 1; capture(); access("R5 cid", 1'b0, 12'h0A8);
    check("R5 cid expect", exp_full, 32'h1234_5678);
    fmt_sel = 0; access("R10 fmt after capture", 1'b0, 12'h0A8);
    hyp_aa64 = 0; fmt_sel = 1; capture(); access("R5 cid aa32 zero", 1'b0, 12'h0A8);
    // R8 write ignored, then read back unchanged
    fmt_sel = 0; access("R8 write", 1'b1, 12'h0A8);
    access("R8 after write", 1'b0, 12'h0A8);
    // R7 lock and power rules
    os_lock = 1; access("R7 oslock", 1'b0, 12'h0A8); access("R7 R8 oslock wr", 1'b1, 12'h0A8);
    os_lock = 0; dbl_lock = 1; access("R7 dlock", 1'b0, 12'h0A8);
    dbl_lock = 0; pwr_on = 0; access("R7 pwr", 1'b0, 12'h0A8);
    pwr_on = 1;
    // R12 other offsets
    access("R12 miss", 1'b0, 12'h0AC); access("R12 miss wr", 1'b1, 12'h000);
    // R1 a read of this register does not capture
    randomize_ctx(); access("R1 no capture on read", 1'b0, 12'h0A8);

    // Random mix
    for (int i = 0; i < 300; i++) begin
      randomize_ctx();
      if ($urandom % 2) capture();
      randomize_ctx();               // R10 / R1: context moves before the read
      pwr_on   = ($urandom % 8) != 0;
      dbl_lock = ($urandom % 8) == 0;
      os_lock  = ($urandom % 8) == 0;
      case ($urandom % 4)
        0: access("R8 rand write", 1'b1, 12'h0A8);
        1: access("R12 rand miss", 1'($urandom), 12'($urandom) | 12'h001);
        default: access("R1 rand read", 1'b0, 12'h0A8);
      endcase
      pwr_on = 1; dbl_lock = 0; os_lock = 0;
      access("R1 R2 R11 rand readback", 1'b0, 12'h0A8);
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule